// File: doc/BRIEF.md
# Communications Interrupt Routing and Control Registers

This block is the register front end of a multi-mode serial communications unit. A simple synchronous register bus (address, write strobe, write data, combinational read data) reaches a small set of control registers. Through them, software chooses which of five interrupt group inputs drive each of five interrupt pins. It also fires one-cycle reset strobes at three protocol engines and sets the two modem-control pins, RTS and DTR.

Each interrupt pin is the OR of the group inputs whose enable bit is set in that pin's select register. The result is registered once so that the pin is free of glitches. The reset register stores nothing: a 1 written to a bit gives one pulse on that engine's strobe, and the register always reads back as zero. RTS and DTR are active-low copies of two stored bits. They follow those bits only while a protocol mode is selected, and are held high when no mode is selected. A 3-bit signal-format field is passed on to the engines only while the PHS mode is selected.

Top module: `comm_ctrl_regs`

## Requirements
- R1: After system reset, every register reads 0, `irq_pin_o` and `blk_rst_o` are 0, `fmt_o` is 0, and `rts_o` and `dtr_o` are 1.
- R2: Select register n (n = 0..4) sits at byte address BASE+0x20+2n. It stores write-data bits [4:0], and bits above 4 read as 0.
- R3: In the cycle after each clock edge, `irq_pin_o[n]` equals the OR over k of (select register n bit k AND `grp_irq_i[k]`). Both values are taken as they stood before that edge, so a select write and a group change in the same cycle give the old select value combined with the new group inputs.
- R4: A write to the reset register at BASE+0x02 raises `blk_rst_o[b]` for exactly one cycle, following the write edge, for every bit b in [2:0] written as 1. Bit 2 is PHS, bit 1 is PDC and bit 0 is HDLC. Bits written as 0 produce no pulse.
- R5: The reset register always reads 0.
- R6: The port register at BASE+0x0A stores write-data bits [3:2] and reads them back in the same positions.
- R7: The mode register at BASE+0x00 stores bits [1:0], coded 01 HDLC, 10 PDC and 11 PHS. While it is not 00, `rts_o` is the inverse of port bit 3 and `dtr_o` is the inverse of port bit 2.
- R8: While the mode register is 00, `rts_o` and `dtr_o` are both 1, whatever the port register holds.
- R9: The format register at BASE+0x10 stores bits [2:0] and reads them back. `fmt_o` equals this field when the mode is 11 and is 0 in every other mode.
- R10: A read of any address that is not mapped returns 0. A write to any address that is not mapped changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| grp_irq_i | input | 5 | Interrupt group inputs |
| irq_pin_o | output | 5 | Routed interrupt pins, registered |
| blk_rst_o | output | 3 | Reset strobes: [2] PHS, [1] PDC, [0] HDLC |
| rts_o | output | 1 | Request-to-send pin, active low |
| dtr_o | output | 1 | Data-terminal-ready pin, active low |
| fmt_o | output | 3 | Signal format, valid only in PHS mode |

## Verification
Routing and register update can fall in the same clock: a select-register write can land in the same cycle as a change on the group inputs. The bench provokes this by driving a new group pattern and a new select value in one cycle. It expects the pin in the following cycle to show the old select value combined with the new inputs, and the pin one cycle later to show the new select value. Reset strobes are also fired while the routing sweep leaves group inputs active, and the interrupt pins are judged unchanged by them.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int NUM_GRP  = 5;
    localparam int NUM_OUT  = 5;
    localparam int NUM_RST  = 3;
    localparam int MODE_W   = 2;
    localparam int PORT_W   = 2;
    localparam int PORT_LSB = 2;
    localparam int FMT_W    = 3;

    localparam int OFF_MODE   = 'h00;
    localparam int OFF_RST    = 'h02;
    localparam int OFF_PORT   = 'h0A;
    localparam int OFF_FMT    = 'h10;
    localparam int OFF_SEL    = 'h20;
    localparam int SEL_STRIDE = 2;

    localparam logic [MODE_W-1:0] MODE_NONE = 2'b00;
    localparam logic [MODE_W-1:0] MODE_HDLC = 2'b01;
    localparam logic [MODE_W-1:0] MODE_PDC  = 2'b10;
    localparam logic [MODE_W-1:0] MODE_PHS  = 2'b11;

    typedef struct packed {
        logic [MODE_W-1:0]               mode;
        logic [PORT_W-1:0]               port;
        logic [FMT_W-1:0]                fmt;
        logic [NUM_OUT-1:0][NUM_GRP-1:0] sel;
        logic [NUM_RST-1:0]              strb;
        logic [NUM_OUT-1:0]              irq;
    } ccr_state_t;
endpackage

// File: rtl/ccr_addr_decode.sv
module ccr_addr_decode
    import ccr_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h200000
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit_mode,
    output logic               hit_rst,
    output logic               hit_port,
    output logic               hit_fmt,
    output logic [NUM_OUT-1:0] hit_sel,
    output logic               hit_any
);
    assign hit_mode = (addr == BASE_ADDR + ADDR_W'(OFF_MODE));
    assign hit_rst  = (addr == BASE_ADDR + ADDR_W'(OFF_RST));
    assign hit_port = (addr == BASE_ADDR + ADDR_W'(OFF_PORT));
    assign hit_fmt  = (addr == BASE_ADDR + ADDR_W'(OFF_FMT));

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_sel
        assign hit_sel[n] = (addr == BASE_ADDR + ADDR_W'(OFF_SEL + SEL_STRIDE * n));
    end

    assign hit_any = hit_mode | hit_rst | hit_port | hit_fmt | (|hit_sel);
endmodule

// File: rtl/ccr_irq_matrix.sv
module ccr_irq_matrix
    import ccr_pkg::*;
(
    input  logic [NUM_OUT-1:0][NUM_GRP-1:0] sel,
    input  logic [NUM_GRP-1:0]              grp,
    output logic [NUM_OUT-1:0]              route
);
    for (genvar n = 0; n < NUM_OUT; n++) begin : g_row
        assign route[n] = |(sel[n] & grp);
    end
endmodule

// File: rtl/comm_ctrl_regs.sv
module comm_ctrl_regs
    import ccr_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 24'h200000,
    parameter int                DATA_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_GRP-1:0] grp_irq_i,
    output logic [NUM_OUT-1:0] irq_pin_o,
    output logic [NUM_RST-1:0] blk_rst_o,
    output logic               rts_o,
    output logic               dtr_o,
    output logic [FMT_W-1:0]   fmt_o
);
    localparam int PORT_MSB = PORT_LSB + PORT_W - 1;

    ccr_state_t st_d, st_q;

    logic               hit_mode, hit_rst, hit_port, hit_fmt, hit_any;
    logic [NUM_OUT-1:0] hit_sel;
    logic [NUM_OUT-1:0] route_w;
    logic [MODE_W-1:0]  cur_mode;
    logic               mode_active;
    logic               unused_wdata;

    assign unused_wdata = &{1'b0, bus_wdata[DATA_W-1:NUM_GRP]};

    ccr_addr_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr     (bus_addr),
        .hit_mode (hit_mode),
        .hit_rst  (hit_rst),
        .hit_port (hit_port),
        .hit_fmt  (hit_fmt),
        .hit_sel  (hit_sel),
        .hit_any  (hit_any)
    );

    ccr_irq_matrix u_mtx (
        .sel   (st_q.sel),
        .grp   (grp_irq_i),
        .route (route_w)
    );

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.strb = '0;
        st_d.irq  = route_w;
        if (bus_wr) begin
            if (hit_mode) st_d.mode = bus_wdata[MODE_W-1:0];
            if (hit_rst)  st_d.strb = bus_wdata[NUM_RST-1:0];
            if (hit_port) st_d.port = bus_wdata[PORT_MSB:PORT_LSB];
            if (hit_fmt)  st_d.fmt  = bus_wdata[FMT_W-1:0];
            for (int n = 0; n < NUM_OUT; n++) begin
                if (hit_sel[n]) st_d.sel[n] = bus_wdata[NUM_GRP-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux; the reset register and unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (hit_mode) bus_rdata[MODE_W-1:0]      = st_q.mode;
        if (hit_port) bus_rdata[PORT_MSB:PORT_LSB] = st_q.port;
        if (hit_fmt)  bus_rdata[FMT_W-1:0]       = st_q.fmt;
        for (int n = 0; n < NUM_OUT; n++) begin
            if (hit_sel[n]) bus_rdata[NUM_GRP-1:0] = st_q.sel[n];
        end
    end

    assign cur_mode    = st_q.mode;
    assign mode_active = (cur_mode != MODE_NONE);
    assign rts_o       = mode_active ? ~st_q.port[1] : 1'b1;
    assign dtr_o       = mode_active ? ~st_q.port[0] : 1'b1;
    assign fmt_o       = (cur_mode == MODE_PHS) ? st_q.fmt : '0;
    assign irq_pin_o   = st_q.irq;
    assign blk_rst_o   = st_q.strb;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import ccr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               hit_rst,
    input logic               hit_any,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_GRP-1:0] grp_irq_i,
    input logic [NUM_OUT-1:0] irq_pin_o,
    input logic [NUM_RST-1:0] blk_rst_o,
    input logic               rts_o,
    input logic               dtr_o,
    input logic [MODE_W-1:0]  cur_mode,
    input logic [FMT_W-1:0]   fmt_o
);
    assert_irq_needs_grp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin_o != '0) |-> ($past(grp_irq_i) != '0));

    assert_strobe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_rst_o != '0) |-> $past(bus_wr && hit_rst));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit_rst) |=> (blk_rst_o == '0));

    assert_rst_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rst |-> (bus_rdata == '0));

    assert_pins_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode != MODE_NONE) && ($past(cur_mode) != MODE_NONE) && !$past(bus_wr))
        |-> ($stable(rts_o) && $stable(dtr_o)));

    assert_idle_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_NONE) |-> (rts_o && dtr_o));

    assert_fmt_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != MODE_PHS) |-> (fmt_o == '0));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |-> (bus_rdata == '0));
endmodule

bind comm_ctrl_regs ccr_checker #(.DATA_W(DATA_W)) u_ccr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .hit_rst   (hit_rst),
    .hit_any   (hit_any),
    .bus_rdata (bus_rdata),
    .grp_irq_i (grp_irq_i),
    .irq_pin_o (irq_pin_o),
    .blk_rst_o (blk_rst_o),
    .rts_o     (rts_o),
    .dtr_o     (dtr_o),
    .cur_mode  (cur_mode),
    .fmt_o     (fmt_o)
);

// File: tb/comm_ctrl_regs_bench.sv
module comm_ctrl_regs_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW   = 24;
    localparam int          DW   = 16;
    localparam logic [23:0] BASE = 24'h200000;
    localparam logic [23:0] A_MODE = BASE + 24'h00;
    localparam logic [23:0] A_RST  = BASE + 24'h02;
    localparam logic [23:0] A_PORT = BASE + 24'h0A;
    localparam logic [23:0] A_FMT  = BASE + 24'h10;
    localparam logic [23:0] A_IDLE = 24'hFFFFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = A_IDLE;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [4:0]    grp_irq_i = '0;
    logic [4:0]    irq_pin_o;
    logic [2:0]    blk_rst_o;
    logic          rts_o, dtr_o;
    logic [2:0]    fmt_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    comm_ctrl_regs u_comm_ctrl_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .grp_irq_i (grp_irq_i),
        .irq_pin_o (irq_pin_o),
        .blk_rst_o (blk_rst_o),
        .rts_o     (rts_o),
        .dtr_o     (dtr_o),
        .fmt_o     (fmt_o)
    );

    function automatic logic [23:0] sel_addr(input int n);
        return BASE + 24'h20 + 24'(2 * n);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_IDLE; bus_wdata = '0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = A_IDLE;
    endtask

    function automatic logic [4:0] route(input logic [4:0] s [5], input logic [4:0] g);
        logic [4:0] r;
        for (int n = 0; n < 5; n++) r[n] = |(s[n] & g);
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [4:0]  s [5];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 irq", irq_pin_o, 0);
        check("R1 strobe", blk_rst_o, 0);
        check("R1 rts", rts_o, 1);
        check("R1 dtr", dtr_o, 1);
        check("R1 fmt", fmt_o, 0);
        rd(A_MODE, d); check("R1 mode reg", d, 0);
        rd(A_PORT, d); check("R1 port reg", d, 0);
        rd(A_FMT,  d); check("R1 fmt reg", d, 0);
        for (int n = 0; n < 5; n++) begin
            rd(sel_addr(n), d); check("R1 sel reg", d, 0);
        end

        // R2: select register width and readback
        for (int n = 0; n < 5; n++) begin
            wr(sel_addr(n), 16'hFFFF);
            rd(sel_addr(n), d); check("R2 sel full", d, 16'h001F);
            wr(sel_addr(n), 16'h0000);
            rd(sel_addr(n), d); check("R2 sel clear", d, 0);
        end

        // R3: sweep select patterns and all group inputs
        for (int p = 0; p < 32; p++) begin
            for (int n = 0; n < 5; n++) begin
                s[n] = 5'((p + 7 * n + n * n * p) & 31);
                wr(sel_addr(n), 16'(s[n]));
            end
            for (int g = 0; g < 32; g++) begin
                @(negedge clk);
                grp_irq_i = 5'(g);
                @(negedge clk);
                check("R3 routing", irq_pin_o, route(s, 5'(g)));
            end
        end

        // R3: select write and group change in the same cycle
        wr(sel_addr(0), 16'h0003);
        @(negedge clk);
        grp_irq_i = 5'b00101;
        bus_addr = sel_addr(0); bus_wr = 1'b1; bus_wdata = 16'h0010;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_IDLE;
        check("R3 same-cycle old select", irq_pin_o[0], 1);
        @(negedge clk);
        check("R3 same-cycle new select", irq_pin_o[0], 0);

        // R4/R5: reset strobes, with group inputs still routing
        s[0] = 5'h10;
        for (int n = 1; n < 5; n++) begin
            rd(sel_addr(n), d); s[n] = d[4:0];
        end
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            grp_irq_i = 5'(v * 3 + 1);
            bus_addr = A_RST; bus_wr = 1'b1; bus_wdata = 16'(v) | 16'hFFF8;
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = A_IDLE;
            check("R4 strobe pulse", blk_rst_o, v);
            check("R3 irq during strobe", irq_pin_o, route(s, 5'(v * 3 + 1)));
            @(negedge clk);
            check("R4 strobe single cycle", blk_rst_o, 0);
            rd(A_RST, d); check("R5 reset reg reads zero", d, 0);
        end
        grp_irq_i = '0;

        // R6/R7/R8: mode and port
        for (int m = 0; m < 4; m++) begin
            wr(A_MODE, 16'(m));
            rd(A_MODE, d); check("R7 mode readback", d, m);
            for (int p = 0; p < 4; p++) begin
                wr(A_PORT, 16'(p << 2) | 16'hFFF3);
                rd(A_PORT, d); check("R6 port readback", d, p << 2);
                #1;
                if (m == 0) begin
                    check("R8 rts idle", rts_o, 1);
                    check("R8 dtr idle", dtr_o, 1);
                end else begin
                    check("R7 rts", rts_o, ((p >> 1) & 1) ^ 1);
                    check("R7 dtr", dtr_o, (p & 1) ^ 1);
                end
            end
            // R9: format field gated by PHS mode
            for (int f = 0; f < 8; f++) begin
                wr(A_FMT, 16'(f) | 16'hFFF8);
                rd(A_FMT, d); check("R9 fmt readback", d, f);
                check("R9 fmt output", fmt_o, (m == 3) ? f : 0);
            end
        end

        // R10: unmapped accesses
        wr(A_MODE, 16'h0001);
        wr(A_PORT, 16'h000C);
        wr(sel_addr(0), 16'h001F);
        wr(BASE + 24'h2A, 16'hFFFF);
        wr(BASE + 24'h04, 16'h0000);
        wr(BASE + 24'h21, 16'h0000);
        wr(BASE + 24'h01, 16'h0000);
        wr(24'h000020, 16'h0000);
        wr(24'h000000, 16'h0000);
        rd(sel_addr(0), d); check("R10 sel0 unchanged", d, 16'h001F);
        rd(A_MODE, d);      check("R10 mode unchanged", d, 1);
        rd(A_PORT, d);      check("R10 port unchanged", d, 16'h000C);
        check("R10 rts unchanged", rts_o, 0);
        check("R10 dtr unchanged", dtr_o, 0);
        check("R10 no strobe", blk_rst_o, 0);
        rd(BASE + 24'h2A, d); check("R10 unmapped read", d, 0);
        rd(BASE + 24'h04, d); check("R10 unmapped read", d, 0);
        rd(BASE + 24'h21, d); check("R10 unmapped read odd", d, 0);
        rd(24'h000020, d);    check("R10 foreign base read", d, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule